// File: doc/BRIEF.md
# Four-Channel Leaky Digital Integrator for di/dt Current Sensors

A di/dt current sensor produces a voltage proportional to the rate of change of current. This block recovers the current waveform by integrating that signal in the digital domain. It serves three phase channels and a neutral channel, or `NCH` channels in general. Each channel keeps its own accumulator. A single arithmetic datapath is shared and visits the channels one after another. The integrator is leaky: every step removes a fixed fraction (2^-LEAK_SH) of the stored value. A DC component therefore settles to a bounded level instead of ramping. The response falls at roughly 20 dB per decade, with close to -90 degrees of phase shift, above the very low leak corner.

A small configuration register chooses the mode. When its bit 0 is set, samples are integrated. When it is clear, samples pass through untouched and all accumulators are held at zero. The register resets to zero, so the block starts in pass-through mode. A set of samples for all channels arrives with one valid strobe. The block answers with one output strobe per set, after a fixed latency of `NCH` cycles.

Top module: `di_dt_integrator`

## Requirements
- R1: While `rst_n` is low, and after any clock edge with `rst_n` low, `out_valid` is 0, `out_data` is all zeros and `cfg_rdata` is 0. Integration is therefore off after reset.
- R2: If bit 0 of the configuration register was 0 when a set was captured, each channel's output equals its input sample exactly. Channel c sits at bits [c*SMP_W +: SMP_W] of both `in_data` and `out_data`.
- R3: In integrate mode, each channel updates its own state as acc = acc - (acc >>> LEAK_SH) + x, where the shift is arithmetic. The result for that channel is acc >>> OUT_SH. Channels never share state.
- R4: The accumulator is ACC_W bits wide and signed. It saturates at the most positive and most negative ACC_W-bit values instead of wrapping.
- R5: The scaled output saturates to the SMP_W-bit signed range. A steady maximum-positive input eventually gives 2^(SMP_W-1)-1, and a steady maximum-negative input gives -2^(SMP_W-1).
- R6: Every set processed in pass-through mode clears all accumulators to zero. After the block is re-enabled, the first integrated output of a channel is x >>> OUT_SH.
- R7: The mode is sampled from bit 0 of the configuration register only when a set is captured. A register write while a set is in progress affects the next set, not the current one.
- R8: An `in_valid` pulse that arrives while a set is still being processed is ignored. It changes neither that set's results nor the number of output strobes.
- R9: A write with `cfg_wr` high stores `cfg_wdata` in full. The stored value is read back on `cfg_rdata` from the following cycle onward.
- R10: Channels are processed in ascending order, one per cycle. `out_valid` pulses high for exactly one cycle, `NCH` cycles after the capture edge, and there is exactly one pulse per captured set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration write value; bit 0 selects integration |
| cfg_rdata | output | CFG_W | Configuration register contents |
| in_valid | input | 1 | A full sample set is present on `in_data` |
| in_data | input | NCH*SMP_W | Signed input samples, channel c at [c*SMP_W +: SMP_W] |
| out_valid | output | 1 | One-cycle strobe: results for a full set are valid |
| out_data | output | NCH*SMP_W | Signed results, channel c at [c*SMP_W +: SMP_W] |

## Verification
The bench builds the block with four 24-bit channels, a 26-bit accumulator, a leak shift of 4 and an output shift of 1. With a leak of 1/16, a full-scale DC input drives the accumulator into its positive or negative limit within a few dozen sets. Because ACC_W - OUT_SH exceeds SMP_W, the saturating output variant is selected, so both clamp stages can be observed at the ports in a short run. The default parameters select the non-saturating output variant, which is elaborated separately.

// File: rtl/di_int_pkg.sv
package di_int_pkg;

   // Processing mode latched at the start of each sample set.
   typedef enum logic {
      DI_PASS  = 1'b0,
      DI_INTEG = 1'b1
   } di_mode_e;

endpackage

// File: rtl/di_int_cfg.sv
module di_int_cfg #(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output logic             integ_req
);

   logic [CFG_W-1:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_q <= '0;
      else if (wr) reg_q <= wdata;
   end

   assign rdata     = reg_q;
   assign integ_req = reg_q[0];

endmodule

// File: rtl/di_int_seq.sv
module di_int_seq
   import di_int_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int SMP_W = 24,
   parameter int CH_W  = $clog2(NCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [NCH*SMP_W-1:0] in_data,
   input  logic                 integ_req,
   output logic [NCH*SMP_W-1:0] smp_q,
   output di_mode_e             mode_q,
   output logic [CH_W-1:0]      ch_q,
   output logic                 busy_q,
   output logic                 last
);

   localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

   logic start;

   assign start = in_valid && !busy_q;
   assign last  = busy_q && (ch_q == CH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= '0;
         mode_q <= DI_PASS;
         ch_q   <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         smp_q  <= in_data;
         mode_q <= integ_req ? DI_INTEG : DI_PASS;
         ch_q   <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (last) begin
            busy_q <= 1'b0;
            ch_q   <= '0;
         end else begin
            ch_q <= ch_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/di_int_lane.sv
module di_int_lane
   import di_int_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int SMP_W   = 24,
   parameter int ACC_W   = 32,
   parameter int LEAK_SH = 12,
   parameter int OUT_SH  = 8,
   parameter int CH_W    = $clog2(NCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 last,
   input  logic [CH_W-1:0]      ch,
   input  di_mode_e             mode,
   input  logic [NCH*SMP_W-1:0] smp_flat,
   output logic [NCH*SMP_W-1:0] out_flat,
   output logic [NCH*ACC_W-1:0] acc_flat,
   output logic                 out_valid
);

   localparam int SUM_W = ACC_W + 2;
   localparam int OVF_W = ACC_W - SMP_W + 1;

   logic signed [ACC_W-1:0] acc_q [NCH];
   logic signed [SMP_W-1:0] res_q [NCH];

   logic signed [SMP_W-1:0] x_cur;
   logic signed [ACC_W-1:0] a_cur;
   logic signed [ACC_W-1:0] a_leak;
   logic signed [SUM_W-1:0] sum;
   logic signed [ACC_W-1:0] a_next;
   logic signed [ACC_W-1:0] shifted;
   logic signed [SMP_W-1:0] y_cur;

   assign x_cur  = smp_flat[ch*SMP_W +: SMP_W];
   assign a_cur  = acc_q[ch];
   assign a_leak = a_cur >>> LEAK_SH;

   // Shared datapath: leak, add, clamp to the accumulator range.
   always_comb begin
      sum = {{2{a_cur[ACC_W-1]}}, a_cur}
          - {{2{a_leak[ACC_W-1]}}, a_leak}
          + {{(SUM_W-SMP_W){x_cur[SMP_W-1]}}, x_cur};
      if (sum[SUM_W-1:ACC_W-1] == {3{sum[SUM_W-1]}})
         a_next = sum[ACC_W-1:0];
      else if (sum[SUM_W-1])
         a_next = {1'b1, {(ACC_W-1){1'b0}}};
      else
         a_next = {1'b0, {(ACC_W-1){1'b1}}};
   end

   assign shifted = a_next >>> OUT_SH;

   // Output scaling: clamp only when the shifted range can exceed the sample width.
   generate
      if (ACC_W - OUT_SH > SMP_W) begin : g_sat_out
         always_comb begin
            if (shifted[ACC_W-1:SMP_W-1] == {OVF_W{shifted[ACC_W-1]}})
               y_cur = shifted[SMP_W-1:0];
            else if (shifted[ACC_W-1])
               y_cur = {1'b1, {(SMP_W-1){1'b0}}};
            else
               y_cur = {1'b0, {(SMP_W-1){1'b1}}};
         end
      end else begin : g_fit_out
         assign y_cur = shifted[SMP_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            acc_q[i] <= '0;
            res_q[i] <= '0;
         end
         out_valid <= 1'b0;
      end else begin
         out_valid <= step && last;
         if (step) begin
            if (mode == DI_INTEG) begin
               acc_q[ch] <= a_next;
               res_q[ch] <= y_cur;
            end else begin
               acc_q[ch] <= '0;
               res_q[ch] <= x_cur;
            end
         end
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_flat
         assign out_flat[g*SMP_W +: SMP_W] = res_q[g];
         assign acc_flat[g*ACC_W +: ACC_W] = acc_q[g];
      end
   endgenerate

endmodule

// File: rtl/di_dt_integrator.sv
module di_dt_integrator
   import di_int_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int SMP_W   = 24,
   parameter int ACC_W   = 32,
   parameter int LEAK_SH = 12,
   parameter int OUT_SH  = 8,
   parameter int CFG_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_rdata,
   input  logic                 in_valid,
   input  logic [NCH*SMP_W-1:0] in_data,
   output logic                 out_valid,
   output logic [NCH*SMP_W-1:0] out_data
);

   localparam int CH_W = $clog2(NCH);

   generate
      if (NCH < 2)             begin : g_bad_nch   $error("NCH must be at least 2");        end
      if (ACC_W <= SMP_W)      begin : g_bad_acc   $error("ACC_W must exceed SMP_W");       end
      if (LEAK_SH < 1 || LEAK_SH >= ACC_W)
                               begin : g_bad_leak  $error("LEAK_SH out of range");          end
      if (OUT_SH < 0 || OUT_SH >= ACC_W)
                               begin : g_bad_osh   $error("OUT_SH out of range");           end
      if (CFG_W < 1)           begin : g_bad_cfg   $error("CFG_W must be at least 1");      end
   endgenerate

   logic                 integ_req;
   logic [NCH*SMP_W-1:0] smp_flat;
   di_mode_e             mode;
   logic [CH_W-1:0]      ch;
   logic                 busy;
   logic                 last;
   logic [NCH*ACC_W-1:0] acc_flat;

   di_int_cfg #(.CFG_W(CFG_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .integ_req (integ_req)
   );

   di_int_seq #(.NCH(NCH), .SMP_W(SMP_W), .CH_W(CH_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .integ_req (integ_req),
      .smp_q     (smp_flat),
      .mode_q    (mode),
      .ch_q      (ch),
      .busy_q    (busy),
      .last      (last)
   );

   di_int_lane #(
      .NCH(NCH), .SMP_W(SMP_W), .ACC_W(ACC_W),
      .LEAK_SH(LEAK_SH), .OUT_SH(OUT_SH), .CH_W(CH_W)
   ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (busy),
      .last      (last),
      .ch        (ch),
      .mode      (mode),
      .smp_flat  (smp_flat),
      .out_flat  (out_data),
      .acc_flat  (acc_flat),
      .out_valid (out_valid)
   );

endmodule

// File: rtl/di_int_check.sv
module di_int_check
   import di_int_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int SMP_W = 24,
   parameter int ACC_W = 32,
   parameter int CFG_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 out_valid,
   input logic [NCH*SMP_W-1:0] out_data,
   input logic [CFG_W-1:0]     cfg_rdata,
   input logic [NCH*SMP_W-1:0] smp_flat,
   input logic [NCH*ACC_W-1:0] acc_flat,
   input di_mode_e             mode,
   input logic                 busy
);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_data == '0 && cfg_rdata == '0));

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode == DI_PASS) |-> out_data == smp_flat);

   assert_clear_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode == DI_PASS) |-> acc_flat == '0);

   assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode));

   assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_valid) |=> $stable(smp_flat));

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

bind di_dt_integrator di_int_check #(
   .NCH(NCH), .SMP_W(SMP_W), .ACC_W(ACC_W), .CFG_W(CFG_W)
) u_di_int_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data),
   .cfg_rdata (cfg_rdata),
   .smp_flat  (smp_flat),
   .acc_flat  (acc_flat),
   .mode      (mode),
   .busy      (busy)
);

// File: tb/test_di_dt_integrator.sv
module test_di_dt_integrator;

   localparam int CLK_PERIOD = 10;
   localparam int NCH     = 4;
   localparam int SMP_W   = 24;
   localparam int ACC_W   = 26;
   localparam int LEAK_SH = 4;
   localparam int OUT_SH  = 1;
   localparam int CFG_W   = 8;

   localparam longint ACC_MAX = (64'sd1 <<< (ACC_W-1)) - 1;
   localparam longint ACC_MIN = -(64'sd1 <<< (ACC_W-1));
   localparam longint SMP_MAX = (64'sd1 <<< (SMP_W-1)) - 1;
   localparam longint SMP_MIN = -(64'sd1 <<< (SMP_W-1));

   // Vector table: mode bit and four channel samples per row.
   localparam int NV = 8;
   localparam logic [NV-1:0] V_EN = 8'b1111_0000;
   localparam logic signed [SMP_W-1:0] V_X [NV][NCH] = '{
      '{24'sd1,       -24'sd1,       24'sd0,        24'sd12345},
      '{24'sh7FFFFF,  24'sh800000,   24'sd100,      -24'sd100},
      '{24'sh123456,  24'sh654321,   24'shFEDCBA,   24'sh000001},
      '{24'sd0,       24'sd0,        24'sd0,        24'sd0},
      '{24'sd1000,    -24'sd1000,    24'sd7,        24'sd0},
      '{24'sd1000,    -24'sd1000,    24'sd7,        24'sd3},
      '{24'sd50000,   24'sd20,       -24'sd33,      24'sd3},
      '{-24'sd4000,   24'sd20,       24'sd0,        24'sh7FFFFF}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cfg_wr = 1'b0;
   logic [CFG_W-1:0]     cfg_wdata = '0;
   logic [CFG_W-1:0]     cfg_rdata;
   logic                 in_valid = 1'b0;
   logic [NCH*SMP_W-1:0] in_data = '0;
   logic                 out_valid;
   logic [NCH*SMP_W-1:0] out_data;

   int     n_tests = 0;
   int     n_fail  = 0;
   int     n_pulse = 0;
   bit     model_en = 1'b0;
   longint macc [NCH];
   longint expv [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (out_valid) n_pulse++;

   di_dt_integrator #(
      .NCH(NCH), .SMP_W(SMP_W), .ACC_W(ACC_W),
      .LEAK_SH(LEAK_SH), .OUT_SH(OUT_SH), .CFG_W(CFG_W)
   ) i_di_dt_integrator (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic longint clampv(longint v, longint lo, longint hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [CFG_W-1:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      model_en = v[0];
   endtask

   // Model update of one set, from the requirement equations (R2, R3, R4, R5, R6).
   task automatic model_set(input logic signed [SMP_W-1:0] xs [NCH], input bit en);
      for (int c = 0; c < NCH; c++) begin
         longint x = longint'(xs[c]);
         if (en) begin
            macc[c] = clampv(macc[c] - (macc[c] >>> LEAK_SH) + x, ACC_MIN, ACC_MAX);
            expv[c] = clampv(macc[c] >>> OUT_SH, SMP_MIN, SMP_MAX);
         end else begin
            macc[c] = 0;
            expv[c] = x;
         end
      end
   endtask

   task automatic run_set(input logic signed [SMP_W-1:0] xs [NCH], input string tag,
                          input bit mid_cfg, input logic [CFG_W-1:0] mid_val,
                          input bit glitch, input bit verify);
      int lat;
      int p0;
      bit en_now;
      en_now = model_en;
      @(negedge clk);
      for (int c = 0; c < NCH; c++) in_data[c*SMP_W +: SMP_W] = xs[c];
      in_valid = 1'b1;
      p0 = n_pulse;
      @(negedge clk);
      in_valid = 1'b0;
      if (glitch) begin
         in_valid = 1'b1;
         in_data  = ~in_data;
      end
      if (mid_cfg) begin
         cfg_wr = 1'b1; cfg_wdata = mid_val;
      end
      lat = 0;
      while (lat < 10) begin
         @(negedge clk);
         in_valid = 1'b0; cfg_wr = 1'b0;
         lat++;
         if (out_valid) break;
      end
      model_set(xs, en_now);
      if (mid_cfg) model_en = mid_val[0];
      if (verify) begin
         check({tag, " R10 latency"}, lat, NCH);
         for (int c = 0; c < NCH; c++)
            check({tag, " R3/R2 channel data"},
                  longint'($signed(out_data[c*SMP_W +: SMP_W])), expv[c]);
      end
      @(negedge clk);
      if (verify) begin
         check({tag, " R10 strobe width"}, longint'(out_valid), 0);
         check({tag, " R8/R10 one strobe per set"}, n_pulse - p0, 1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic signed [SMP_W-1:0] xs [NCH];
      for (int c = 0; c < NCH; c++) macc[c] = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 out_valid", longint'(out_valid), 0);
      check("R1 out_data", longint'(out_data != '0), 0);
      check("R1 cfg_rdata", longint'(cfg_rdata), 0);
      rst_n = 1'b1;

      // R2: default mode after reset is pass-through
      xs = '{24'sd77, -24'sd5, 24'sh7FFFFF, 24'sh800000};
      run_set(xs, "R2 after reset", 1'b0, '0, 1'b0, 1'b1);

      // Vector table walk
      for (int v = 0; v < NV; v++) begin
         write_cfg({{(CFG_W-1){1'b0}}, V_EN[v]});
         run_set(V_X[v], V_EN[v] ? "R3 vector" : "R2 vector", 1'b0, '0, 1'b0, 1'b1);
      end

      // R9: full-width readback, bit 0 enables
      write_cfg(8'hA5);
      @(negedge clk);
      check("R9 readback", longint'(cfg_rdata), 8'hA5);

      // R4/R5: positive saturation under steady full-scale input
      xs = '{24'sh7FFFFF, 24'sh7FFFFF, 24'sh7FFFFF, 24'sh7FFFFF};
      for (int k = 0; k < 60; k++) run_set(xs, "R4 ramp", 1'b0, '0, 1'b0, k > 55);
      check("R4 accumulator clamp high", macc[0], ACC_MAX);
      check("R5 output clamp high",
            longint'($signed(out_data[0 +: SMP_W])), SMP_MAX);

      // R4/R5: negative saturation
      xs = '{24'sh800000, 24'sh800000, 24'sh800000, 24'sh800000};
      for (int k = 0; k < 60; k++) run_set(xs, "R4 ramp low", 1'b0, '0, 1'b0, k > 55);
      check("R4 accumulator clamp low", macc[3], ACC_MIN);
      check("R5 output clamp low",
            longint'($signed(out_data[3*SMP_W +: SMP_W])), SMP_MIN);

      // R6: one pass-through set clears state; re-enabled output starts from zero
      write_cfg(8'h00);
      xs = '{24'sd9, 24'sd9, 24'sd9, 24'sd9};
      run_set(xs, "R6 pass", 1'b0, '0, 1'b0, 1'b1);
      write_cfg(8'h01);
      xs = '{24'sd100, -24'sd100, 24'sd3, 24'sd0};
      run_set(xs, "R6 restart", 1'b0, '0, 1'b0, 1'b1);
      check("R6 first output", longint'($signed(out_data[0 +: SMP_W])), 50);
      check("R6 first negative output",
            longint'($signed(out_data[SMP_W +: SMP_W])), -50);

      // R7: disable written mid-set applies from the next set
      xs = '{24'sd200, 24'sd200, 24'sd200, 24'sd200};
      run_set(xs, "R7 in-flight set", 1'b1, 8'h00, 1'b0, 1'b1);
      check("R7 mode kept for current set",
            longint'($signed(out_data[0 +: SMP_W])) != 200 ? 1 : 0, 1);
      xs = '{24'sd321, -24'sd321, 24'sd5, 24'sd6};
      run_set(xs, "R7 next set pass", 1'b0, '0, 1'b0, 1'b1);

      // R8: strobe during processing is dropped
      write_cfg(8'h01);
      xs = '{24'sd4096, 24'sd2048, -24'sd1024, 24'sd512};
      run_set(xs, "R8 glitch integ", 1'b0, '0, 1'b1, 1'b1);
      write_cfg(8'h00);
      xs = '{24'sd11, 24'sd22, 24'sd33, 24'sd44};
      run_set(xs, "R8 glitch pass", 1'b0, '0, 1'b1, 1'b1);

      // R1: reset mid-run clears configuration and outputs
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = 8'hFF;
      @(negedge clk);
      cfg_wr = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 cfg after reset", longint'(cfg_rdata), 0);
      check("R1 data after reset", longint'(out_data != '0), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule